// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides, in a single step, which exception the core takes when one or more events are pending, and produces every state update that entry needs. The event inputs are a reset request, a fast and a normal interrupt request, a memory-abort strobe, an undefined-instruction strobe and a software-interrupt strobe. The block also reads the current program counter and status word. When an event is accepted, it emits the following one clock later:

- a one-cycle take strobe;
- the new mode;
- the updated status word with the interrupt masks raised;
- the vector address that becomes the next program counter;
- write strobes and data for the new mode's saved-status register and banked link register.

The register file and fetch unit are expected to consume these strobes directly. Each handler applies its own return-address adjustment on exit, so the link value is always the interrupted program counter plus four.

Top module: `exc_entry_seq`

## Requirements
- R1: A reset request is accepted regardless of other inputs and of the masks. It enters supervisor mode (mode code 5'b10011) at vector offset 0x00. It sets both status bit 7 (normal-interrupt mask) and status bit 6 (fast-interrupt mask). It asserts neither the saved-status write nor the link write.
- R2: When several events are pending in the same cycle, exactly one is taken. The precedence is reset, then abort, then unmasked fast interrupt, then unmasked normal interrupt, then undefined instruction, then software interrupt.
- R3: Each event has a fixed mode code and a vector offset from base address VEC_BASE (default 0):
  - abort: mode 5'b10111, offset 0x10;
  - fast interrupt: mode 5'b10001, offset 0x1C;
  - normal interrupt: mode 5'b10010, offset 0x18;
  - undefined instruction: mode 5'b11011, offset 0x04;
  - software interrupt: mode 5'b10011, offset 0x08.
- R4: A fast-interrupt request is ignored while current status bit 6 is set. A normal-interrupt request is ignored while current status bit 7 is set. A masked request alone produces no take, and a masked request never outranks a lower-priority event.
- R5: For every accepted event other than reset, the saved-status write is asserted. Its data equals the status word presented in the cycle the event was sampled.
- R6: For every accepted event other than reset, the link write is asserted. Its data equals the sampled program counter plus 4, modulo 2^32.
- R7: The new status word keeps every bit of the old one, with three exceptions:
  - bits [4:0] take the new mode code;
  - bit 7 is set;
  - bit 6 is additionally set for reset and fast-interrupt entry.
- R8: Outputs change one clock after the event is sampled. The take strobe and both write strobes are high for exactly that one cycle, and stay low in any cycle that follows a cycle with no accepted event.
- R9: While rst_n is low, the following outputs are held at their reset values:
  - take_o, spsr_we_o and lr_we_o are low;
  - mode_o holds the supervisor code;
  - vec_o equals VEC_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer flops |
| rst_req | input | 1 | Reset exception request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| abt_req | input | 1 | Memory access violation strobe |
| und_req | input | 1 | Undefined instruction strobe |
| swi_req | input | 1 | Software interrupt instruction strobe |
| cur_pc | input | XLEN | Program counter of the interrupted mode |
| cur_psr | input | XLEN | Current status word |
| take_o | output | 1 | Exception accepted, one-cycle strobe |
| mode_o | output | 5 | Mode code of the mode entered |
| psr_o | output | XLEN | New status word |
| vec_o | output | XLEN | Vector address for the program counter |
| spsr_we_o | output | 1 | Write strobe for the new mode's saved status |
| spsr_o | output | XLEN | Saved status data |
| lr_we_o | output | 1 | Write strobe for the new mode's link register |
| lr_o | output | XLEN | Link register data |

## Verification
A wrong priority decode or mask test appears at the ports on the clock after the event as the wrong mode code and vector. A dropped mask appears as a take where none is due. Because every output is one register stage from its inputs, a faulty selection can never hide for more than one cycle. For that reason the bench checks each output vector exactly one edge after stimulus. It also covers mixed-event patterns that separate each neighbouring pair in the precedence chain. Link data is checked at the 32-bit wrap, and the saved-status copy against a status word whose upper bits are nonzero.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0,
  parameter int IMASK_BIT = 7,
  parameter int FMASK_BIT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_req,
  input  logic            fiq_req,
  input  logic            irq_req,
  input  logic            abt_req,
  input  logic            und_req,
  input  logic            swi_req,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psr,
  output logic            take_o,
  output logic [4:0]      mode_o,
  output logic [XLEN-1:0] psr_o,
  output logic [XLEN-1:0] vec_o,
  output logic            spsr_we_o,
  output logic [XLEN-1:0] spsr_o,
  output logic            lr_we_o,
  output logic [XLEN-1:0] lr_o
);
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  wire fiq_ok = fiq_req & ~cur_psr[FMASK_BIT];
  wire irq_ok = irq_req & ~cur_psr[IMASK_BIT];

  logic            sel_take, sel_save, sel_setf;
  logic [4:0]      sel_mode;
  logic [7:0]      sel_off;
  logic [XLEN-1:0] psr_n;

  always_comb begin
    sel_take = 1'b1;
    sel_save = 1'b1;
    sel_setf = 1'b0;
    sel_mode = M_SVC;
    sel_off  = 8'h00;
    if (rst_req) begin
      sel_save = 1'b0;
      sel_setf = 1'b1;
    end else if (abt_req) begin
      sel_mode = M_ABT;
      sel_off  = 8'h10;
    end else if (fiq_ok) begin
      sel_mode = M_FIQ;
      sel_off  = 8'h1C;
      sel_setf = 1'b1;
    end else if (irq_ok) begin
      sel_mode = M_IRQ;
      sel_off  = 8'h18;
    end else if (und_req) begin
      sel_mode = M_UND;
      sel_off  = 8'h04;
    end else if (swi_req) begin
      sel_off  = 8'h08;
    end else begin
      sel_take = 1'b0;
      sel_save = 1'b0;
    end
  end

  always_comb begin
    psr_n = cur_psr;
    psr_n[4:0] = sel_mode;
    psr_n[IMASK_BIT] = 1'b1;
    if (sel_setf) psr_n[FMASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      spsr_we_o <= 1'b0;
      lr_we_o   <= 1'b0;
      mode_o    <= M_SVC;
      psr_o     <= '0;
      vec_o     <= VEC_BASE;
      spsr_o    <= '0;
      lr_o      <= '0;
    end else begin
      take_o    <= sel_take;
      spsr_we_o <= sel_save;
      lr_we_o   <= sel_save;
      if (sel_take) begin
        mode_o <= sel_mode;
        psr_o  <= psr_n;
        vec_o  <= VEC_BASE + XLEN'(sel_off);
        spsr_o <= cur_psr;
        lr_o   <= cur_pc + XLEN'(4);
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_req,
  input logic            fiq_req,
  input logic            irq_req,
  input logic            abt_req,
  input logic            und_req,
  input logic            swi_req,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] cur_psr,
  input logic            take_o,
  input logic [4:0]      mode_o,
  input logic [XLEN-1:0] psr_o,
  input logic [XLEN-1:0] vec_o,
  input logic            spsr_we_o,
  input logic [XLEN-1:0] spsr_o,
  input logic            lr_we_o,
  input logic [XLEN-1:0] lr_o
);
  wire any_req = rst_req | fiq_req | irq_req | abt_req | und_req | swi_req;

  p_reset_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> take_o && mode_o == 5'b10011 && vec_o == VEC_BASE && !spsr_we_o && !lr_we_o);

  p_abort_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && abt_req) |=> take_o && mode_o == 5'b10111);

  p_fiq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_req && cur_psr[6] && !rst_req && !abt_req && !irq_req && !und_req && !swi_req) |=> !take_o);

  p_spsr_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !rst_req) |=> (!take_o || (spsr_we_o && spsr_o == $past(cur_psr))));

  p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> (!lr_we_o || lr_o == $past(cur_pc) + XLEN'(4)));

  p_new_psr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> psr_o[7] && psr_o[4:0] == mode_o);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !take_o && !spsr_we_o && !lr_we_o);
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) chk_i (.*);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 0, fiq_req = 0, irq_req = 0, abt_req = 0, und_req = 0, swi_req = 0;
  logic [31:0] cur_pc = '0, cur_psr = '0;
  logic take_o, spsr_we_o, lr_we_o;
  logic [4:0] mode_o;
  logic [31:0] psr_o, vec_o, spsr_o, lr_o;
  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (.*);

  // fields: ev[83:78] = {rst,abt,fiq,irq,und,swi}, psr[77:46], pc[45:14], take[13], mode[12:8], vec[7:0]
  localparam int N = 15;
  localparam logic [83:0] TBL [N] = '{
    {6'b000001, 32'h6000_0010, 32'h0000_1000, 1'b1, 5'b10011, 8'h08},
    {6'b000010, 32'h6000_0010, 32'h0000_2004, 1'b1, 5'b11011, 8'h04},
    {6'b000100, 32'h8000_0010, 32'h0000_3008, 1'b1, 5'b10010, 8'h18},
    {6'b001000, 32'h2000_0010, 32'h0000_400C, 1'b1, 5'b10001, 8'h1C},
    {6'b010000, 32'hF000_0013, 32'hFFFF_FFFC, 1'b1, 5'b10111, 8'h10},
    {6'b100000, 32'h6000_00D0, 32'h0000_5000, 1'b1, 5'b10011, 8'h00},
    {6'b111111, 32'h6000_0010, 32'h0000_6000, 1'b1, 5'b10011, 8'h00},
    {6'b011111, 32'h6000_0010, 32'h0000_7000, 1'b1, 5'b10111, 8'h10},
    {6'b001111, 32'h6000_0010, 32'h0000_8000, 1'b1, 5'b10001, 8'h1C},
    {6'b000111, 32'h6000_0010, 32'h0000_9000, 1'b1, 5'b10010, 8'h18},
    {6'b000011, 32'h6000_0010, 32'h0000_A000, 1'b1, 5'b11011, 8'h04},
    {6'b001000, 32'h0000_0050, 32'h0000_B000, 1'b0, 5'b00000, 8'h00},
    {6'b000100, 32'h0000_0090, 32'h0000_C000, 1'b0, 5'b00000, 8'h00},
    {6'b001100, 32'h0000_0050, 32'h0000_D000, 1'b1, 5'b10010, 8'h18},
    {6'b001010, 32'h0000_00D0, 32'h0000_E000, 1'b1, 5'b11011, 8'h04}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_psr(input logic [31:0] psr, input logic [4:0] m, input logic setf);
    logic [31:0] r = psr;
    r[4:0] = m;
    r[7] = 1'b1;
    if (setf) r[6] = 1'b1;
    return r;
  endfunction

  task automatic drive(input logic [5:0] ev, input logic [31:0] psr, input logic [31:0] pc);
    {rst_req, abt_req, fiq_req, irq_req, und_req, swi_req} = ev;
    cur_psr = psr;
    cur_pc = pc;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 10000) begin
      errors++;
      $display("FAIL watchdog R8: actual %0d cycles expected under 10000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "take", 32'(take_o), 0);
    chk("R9", "mode", 32'(mode_o), 32'h13);
    chk("R9", "vec", vec_o, 0);
    chk("R9", "spsr_we", 32'(spsr_we_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "idle take", 32'(take_o), 0);

    for (int i = 0; i < N; i++) begin
      logic [5:0] ev = TBL[i][83:78];
      logic [31:0] psr = TBL[i][77:46];
      logic [31:0] pc = TBL[i][45:14];
      logic tk = TBL[i][13];
      logic [4:0] m = TBL[i][12:8];
      logic [31:0] v = {24'h0, TBL[i][7:0]};
      logic is_rst = ev[5];
      string tag;
      if ($countones(ev) > 1) tag = "R2";
      else if (!tk) tag = "R4";
      else if (is_rst) tag = "R1";
      else tag = "R3";
      drive(ev, psr, pc);
      @(negedge clk);
      chk(tag, "take", 32'(take_o), 32'(tk));
      if (tk) begin
        chk(tag, "mode", 32'(mode_o), 32'(m));
        chk(tag, "vec", vec_o, v);
        chk("R7", "psr", psr_o, exp_psr(psr, m, is_rst || m == 5'b10001));
        chk(is_rst ? "R1" : "R5", "spsr_we", 32'(spsr_we_o), 32'(!is_rst));
        chk(is_rst ? "R1" : "R6", "lr_we", 32'(lr_we_o), 32'(!is_rst));
        if (!is_rst) begin
          chk("R5", "spsr", spsr_o, psr);
          chk("R6", "lr", lr_o, pc + 32'd4);
        end
      end else begin
        chk("R4", "spsr_we", 32'(spsr_we_o), 0);
        chk("R4", "lr_we", 32'(lr_we_o), 0);
      end
    end

    // R8: strobe lasts one cycle after a single-cycle event
    drive(6'b000001, 32'h10, 32'h40);
    @(negedge clk);
    chk("R8", "take on", 32'(take_o), 1);
    drive(6'b000000, 32'h10, 32'h80);
    @(negedge clk);
    chk("R8", "take off", 32'(take_o), 0);
    chk("R8", "spsr_we off", 32'(spsr_we_o), 0);
    chk("R8", "lr_we off", 32'(lr_we_o), 0);

    // R1: reset taken even with both masks set and other events pending
    drive(6'b111111, 32'hFFFF_FFDF, 32'h100);
    @(negedge clk);
    chk("R1", "mode", 32'(mode_o), 32'h13);
    chk("R1", "psr", psr_o, 32'hFFFF_FFD3);
    chk("R1", "spsr_we", 32'(spsr_we_o), 0);
    drive(6'b000000, 32'h10, 32'h0);

    // R9: asynchronous reset mid-run clears strobes
    drive(6'b000010, 32'h10, 32'h200);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "take async", 32'(take_o), 0);
    chk("R9", "mode async", 32'(mode_o), 32'h13);
    drive(6'b000000, 32'h10, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule